// File: doc/BRIEF.md
# Frame-Rate Locked Oscillator Steering Controller

This block keeps a local audio master oscillator (nominally 11.2896 MHz, which is 256 times a 44.1 kHz sample rate) in step with the frame-sync pulse from a digital audio receiver. It runs entirely on the oscillator clock. A free-running counter divides that clock by 256 down to the frame rate. On each rising edge of the reference, the block reads the counter as a signed phase error. That error is scaled into a correction to a 16-bit steering word, which an external converter turns into the tuning voltage for the oscillator.

The loop starts in a fast-acquisition gain. It watches how often it actually has to correct the word, measured over a fixed number of reference periods. Once corrections have become rare, it moves to a slow gain. In the slow gain the oscillator may wander loosely against the reference. If the phase error grows beyond a drift limit, the loop snaps back to the fast gain.

Each new steering word goes out as a data stream with a one-cycle `dac_valid` beat. The interface has no ready signal. The converter path must accept every beat, because back-pressure cannot be applied and a missed beat is not repeated. `dac_word` holds its value between beats. `loose_lock` is a plain status level.

Top module: `vcxo_pll_ctrl`

## Requirements
- R1: During and after reset, `dac_word` is 0x8000, `dac_valid` is 0 and `loose_lock` is 0 (the fast gain).
- R2: Phase measurement works as follows:
  - An 8-bit divider count is 0 after reset. It advances by one on every clock edge with reset released and wraps from 255 to 0.
  - A `ref_sync` rising edge that is first sampled high at clock edge k is measured against the count held after edge k+1.
  - A count below 128 is a phase error equal to the count. Otherwise the error is the count minus 256, so the range is -128 to +127.
- R3: An error whose magnitude is 0 or 1 is a dead zone. It changes no word and gives no `dac_valid` beat.
- R4: Any other error e produces a new word W - e*64 in the fast gain, or W - e*4 in the slow gain. The gain used is the one in force before that reference edge. The new word appears, with its beat, after clock edge k+2.
- R5: The new word is clamped to 0x0000 at the bottom and to 0xFFFF at the top.
- R6: `dac_valid` is high for exactly one cycle per correction, and `dac_word` changes only in a cycle where `dac_valid` is high.
- R7: In the fast gain, reference edges are grouped into windows of 8. When a window closes with at most 1 correction in it, `loose_lock` rises after that same edge.
- R8: In the slow gain, an error with magnitude above 32 clears `loose_lock` after that edge. A fresh window of 8 starts at the next edge.
- R9: In the slow gain, errors with magnitude 32 or less keep `loose_lock` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, 256 times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_sync | input | 1 | Frame-rate reference from the receiver, asynchronous |
| dac_word | output | 16 | Steering word for the tuning converter |
| dac_valid | output | 1 | One-cycle beat marking a new steering word, no back-pressure |
| loose_lock | output | 1 | High while the slow gain is in force |

## Verification
The embedded properties run on every cycle:
- The detected reference edge is a single-cycle event.
- The output beat lasts one cycle, and the word never moves without a beat.
- A positive error never raises the word.
- The slow gain is entered only as a window closes.
- The slow gain is left only on an oversized error.

The bench scenarios cover what a property cannot state compactly:
- the exact word arithmetic for many random phase offsets in both gains;
- clamping at both rails;
- the dead zone;
- the counting of quiet windows before the slow gain is entered.

// File: rtl/vcxo_pll_pkg.sv
package vcxo_pll_pkg;
  typedef enum logic {
    GAIN_FAST = 1'b0,
    GAIN_SLOW = 1'b1
  } gain_mode_e;
endpackage

// File: rtl/vcxo_phase_det.sv
module vcxo_phase_det #(
  parameter int DIV_LOG2    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DEADBAND    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ref_in,
  output logic                       evt,
  output logic signed [DIV_LOG2-1:0] err,
  output logic        [DIV_LOG2-1:0] mag,
  output logic                       nz
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0]     ref_sh;
  logic [DIV_LOG2-1:0] div_cnt;

  // synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_sh <= '0;
    else        ref_sh <= {ref_sh[SH_W-2:0], ref_in};
  end

  // divide-by-2^DIV_LOG2 counter; its wrap is the divided clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end

  assign evt = ref_sh[SH_W-2] & ~ref_sh[SH_W-1];
  // two's complement reading centres the error on the divided edge
  assign err = $signed(div_cnt);
  assign mag = div_cnt[DIV_LOG2-1] ? (~div_cnt + 1'b1) : div_cnt;
  assign nz  = (mag > DIV_LOG2'(DEADBAND));

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt); // R2
endmodule

// File: rtl/vcxo_loop_filter.sv
module vcxo_loop_filter #(
  parameter int ERR_W    = 8,
  parameter int DAC_W    = 16,
  parameter int HI_SHIFT = 6,
  parameter int LO_SHIFT = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt,
  input  logic signed [ERR_W-1:0] err,
  input  logic                    nz,
  input  logic                    slow,
  output logic [DAC_W-1:0]        word,
  output logic                    valid
);
  localparam int SUM_W = DAC_W + 2;
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);
  localparam logic [DAC_W-1:0] TOP = '1;

  logic signed [SUM_W-1:0] ext, delta, sum;
  logic        [DAC_W-1:0] next_word;

  always_comb begin
    ext   = {{(SUM_W-ERR_W){err[ERR_W-1]}}, err};
    delta = slow ? (ext <<< LO_SHIFT) : (ext <<< HI_SHIFT);
    sum   = $signed({2'b00, word}) - delta;
    if (sum[SUM_W-1])                            next_word = '0;
    else if (sum > $signed({2'b00, TOP}))        next_word = TOP;
    else                                         next_word = sum[DAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= MID;
      valid <= 1'b0;
    end else begin
      valid <= evt & nz;
      if (evt && nz) word <= next_word;
    end
  end

  AST_BEAT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid); // R6
  AST_WORD_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word) |-> valid); // R6
  AST_POS_ERR_NOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && nz && !err[ERR_W-1]) |=> (word <= $past(word))); // R4
endmodule

// File: rtl/vcxo_gain_ctrl.sv
module vcxo_gain_ctrl
  import vcxo_pll_pkg::*;
#(
  parameter int ERR_W      = 8,
  parameter int WIN_EVT    = 8,
  parameter int QUIET_MAX  = 1,
  parameter int RELOCK_ERR = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [ERR_W-1:0] mag,
  input  logic             nz,
  output gain_mode_e       mode
);
  localparam int WC_W = (WIN_EVT > 1) ? $clog2(WIN_EVT) : 1;
  localparam int CC_W = $clog2(WIN_EVT + 1);

  logic [WC_W-1:0] win_cnt;
  logic [CC_W-1:0] corr_cnt, corr_tot;
  logic            big;

  assign big      = (mag > ERR_W'(RELOCK_ERR));
  assign corr_tot = corr_cnt + CC_W'(nz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= GAIN_FAST;
      win_cnt  <= '0;
      corr_cnt <= '0;
    end else if (evt) begin
      if (mode == GAIN_SLOW) begin
        win_cnt  <= '0;
        corr_cnt <= '0;
        if (big) mode <= GAIN_FAST;
      end else if (win_cnt == WC_W'(WIN_EVT - 1)) begin
        win_cnt  <= '0;
        corr_cnt <= '0;
        if (corr_tot <= CC_W'(QUIET_MAX)) mode <= GAIN_SLOW;
      end else begin
        win_cnt  <= win_cnt + 1'b1;
        corr_cnt <= corr_tot;
      end
    end
  end

  AST_SLOW_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode) |-> ($past(evt) && $past(win_cnt) == WC_W'(WIN_EVT - 1))); // R7
  AST_FAST_ON_BIG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode) |-> ($past(evt) && $past(mag) > ERR_W'(RELOCK_ERR))); // R8
endmodule

// File: rtl/vcxo_pll_ctrl.sv
module vcxo_pll_ctrl
  import vcxo_pll_pkg::*;
#(
  parameter int DIV_LOG2   = 8,
  parameter int DAC_W      = 16,
  parameter int HI_SHIFT   = 6,
  parameter int LO_SHIFT   = 2,
  parameter int DEADBAND   = 1,
  parameter int WIN_EVT    = 8,
  parameter int QUIET_MAX  = 1,
  parameter int RELOCK_ERR = 32
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             ref_sync,
  output logic [DAC_W-1:0] dac_word,
  output logic             dac_valid,
  output logic             loose_lock
);
  logic                       evt, nz;
  logic signed [DIV_LOG2-1:0] err;
  logic        [DIV_LOG2-1:0] mag;
  gain_mode_e                 mode;

  vcxo_phase_det #(
    .DIV_LOG2(DIV_LOG2), .SYNC_STAGES(2), .DEADBAND(DEADBAND)
  ) u_pd (
    .clk(osc_clk), .rst_n(rst_n), .ref_in(ref_sync),
    .evt(evt), .err(err), .mag(mag), .nz(nz)
  );

  vcxo_loop_filter #(
    .ERR_W(DIV_LOG2), .DAC_W(DAC_W), .HI_SHIFT(HI_SHIFT), .LO_SHIFT(LO_SHIFT)
  ) u_lf (
    .clk(osc_clk), .rst_n(rst_n), .evt(evt), .err(err), .nz(nz),
    .slow(mode == GAIN_SLOW), .word(dac_word), .valid(dac_valid)
  );

  vcxo_gain_ctrl #(
    .ERR_W(DIV_LOG2), .WIN_EVT(WIN_EVT), .QUIET_MAX(QUIET_MAX),
    .RELOCK_ERR(RELOCK_ERR)
  ) u_gc (
    .clk(osc_clk), .rst_n(rst_n), .evt(evt), .mag(mag), .nz(nz), .mode(mode)
  );

  assign loose_lock = (mode == GAIN_SLOW);
endmodule

// File: tb/vcxo_pll_ctrl_tb.sv
module vcxo_pll_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_sync = 1'b0;
  logic [15:0] dac_word;
  logic        dac_valid, loose_lock;

  int total = 0, bad = 0, cyc = 0;
  int e_word = 32768, e_lo = 0, e_win = 0, e_cc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vcxo_pll_ctrl u_dut (
    .osc_clk(clk), .rst_n(rst_n), .ref_sync(ref_sync),
    .dac_word(dac_word), .dac_valid(dac_valid), .loose_lock(loose_lock)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic int err_of(int c);  // R2
    return (c < 128) ? c : c - 256;
  endfunction

  function automatic int clamp16(int v);  // R5
    if (v < 0) return 0;
    if (v > 65535) return 65535;
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive one reference edge landing on divider count c, check outputs
  task automatic send_ref(int c);
    int e, m, nzv, exp_v;
    do @(negedge clk); while (((cyc + 2) % 256) != c);
    ref_sync = 1'b1;
    e = err_of(c);
    m = (e < 0) ? -e : e;
    nzv = (m > 1);
    exp_v = nzv;
    if (nzv) e_word = clamp16(e_word - e * (e_lo ? 4 : 64));
    if (e_lo) begin
      e_win = 0; e_cc = 0;
      if (m > 32) e_lo = 0;
    end else if (e_win == 7) begin
      if (e_cc + nzv <= 1) e_lo = 1;
      e_win = 0; e_cc = 0;
    end else begin
      e_win++; e_cc += nzv;
    end
    repeat (3) @(negedge clk);
    chk("R6/R3 dac_valid", int'(dac_valid), exp_v);
    chk("R4/R5 dac_word", int'(dac_word), e_word);
    chk("R7/R8/R9 loose_lock", int'(loose_lock), e_lo);
    @(negedge clk);
    chk("R6 beat one cycle", int'(dac_valid), 0);
    @(negedge clk);
    ref_sync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", int'(dac_word), 32768);
    chk("R1 reset valid", int'(dac_valid), 0);
    chk("R1 reset lock", int'(loose_lock), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after release", int'(dac_word), 32768);

    void'($urandom(32'd20240917));
    // random phase offsets, mixed gains (R2, R4)
    for (int i = 0; i < 60; i++) send_ref($urandom_range(0, 255));

    // force fast gain, then drive to the bottom rail (R5, R8)
    send_ref(100);
    for (int i = 0; i < 7; i++) send_ref(127);
    chk("R5 bottom rail", int'(dac_word), 0);
    // drive to the top rail with -128
    for (int i = 0; i < 10; i++) send_ref(128);
    chk("R5 top rail", int'(dac_word), 65535);

    // dead zone (R3)
    send_ref(0); send_ref(1); send_ref(255);

    // quiet windows lead to the slow gain (R7)
    for (int i = 0; i < 16; i++) send_ref(0);
    chk("R7 slow gain reached", int'(loose_lock), 1);

    // slow-gain steps within the drift limit (R9, R4)
    send_ref(10); send_ref(250); send_ref(32); send_ref(224);
    chk("R9 still slow", int'(loose_lock), 1);

    // drift limit exceeded (R8)
    send_ref(40);
    chk("R8 back to fast", int'(loose_lock), 0);

    // busy window keeps the fast gain (R7)
    for (int i = 0; i < 8; i++) send_ref(i % 2 ? 5 : 251);
    chk("R7 busy stays fast", int'(loose_lock), 0);

    for (int i = 0; i < 40; i++) send_ref($urandom_range(0, 255));

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule